// File: doc/BRIEF.md
# Cascadable Serial Command and Fault Shifter

This block is the serial side of a four-channel low-side switch controller. A host frames each transfer with an active-low select line and sends one on/off command bit per channel. In the same transfer it reads back one fault bit per channel. Each command bit of 1 turns its channel on, and each command bit of 0 turns it off. A fault bit of 1 reports a fault on that channel.

The select, serial clock and serial data pins are asynchronous to the block. They pass through two-flop synchronizers, and every edge is found in the system clock domain. When select goes low, the present fault vector is loaded into the shift register and the serial output is driven. Fault bits leave first, channel 3 first. After them come the command bits received earlier in the frame, so several blocks can be chained output-to-input. When select goes high, the output enable drops. If at least four bits arrived, the last four of them are committed to the channel control register. A one-cycle pulse also tells the fault logic to clear and re-arm.

The serial clock must run at no more than a quarter of the system clock rate.

Top module: `cmd_fault_shifter`

## Requirements
- R1: While reset is low and right after it is released, `ctrl_q` is 0, `ser_out_en` is 0 and `fault_rearm` is 0.
- R2: After a falling edge of `sel_n`, `ser_out_en` is 1. `ser_out` then shows the snapshot of `fault_live[3]` taken at that edge.
- R3: `ser_out` changes only after a falling edge of `ser_clk` and holds across a rising edge. Its sequence is the fault snapshot bits 3, 2, 1, 0, followed by the `ser_in` bits in the order they were received.
- R4: `ser_in` is sampled on a rising edge of `ser_clk`. On a rising edge of `sel_n` after exactly four bits, `ctrl_q[3]` takes the first bit received and `ctrl_q[0]` the last.
- R5: A frame with fewer than four `ser_clk` rising edges leaves `ctrl_q` unchanged.
- R6: In a frame of more than four bits, `ctrl_q` takes the last four bits received, the earliest of those four going to `ctrl_q[3]`.
- R7: A change on `fault_live` while `sel_n` is low does not alter the fault bits shifted out in that frame.
- R8: Each rising edge of `sel_n` drops `ser_out_en` to 0 and gives exactly one single-cycle `fault_rearm` pulse.
- R9: `ser_clk` and `ser_in` activity while `sel_n` is high changes neither `ctrl_q` nor `ser_out_en`. The next frame still starts with the fault snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Frame select pin, active low, asynchronous |
| ser_clk | input | 1 | Serial clock pin, asynchronous |
| ser_in | input | 1 | Serial command data pin |
| fault_live | input | 4 | Live per-channel fault vector, bit i = channel i |
| ser_out | output | 1 | Serial output data (fault bits, then pass-through) |
| ser_out_en | output | 1 | Tri-state enable for `ser_out`, 1 = drive |
| ctrl_q | output | 4 | Channel on/off control register, bit i = channel i |
| fault_rearm | output | 1 | One-cycle pulse to clear and re-arm fault capture |

## Verification
A shift register that is off by one position shows up at once in the serial stream. The first pass-through bit appears one `ser_clk` period early or late. `ctrl_q` then holds a rotated pattern after the very next select rise. A bit counter that does not reset per frame, or does not saturate, shows on the first short frame after a full one. It either wrongly updates `ctrl_q` or fails to update it after a long frame. A stale or refreshed snapshot is seen in the first four output bits of the frame in which the fault vector moves.

// File: rtl/cfs_pkg.sv
`timescale 1ns/1ps
package cfs_pkg;

  typedef struct packed {
    logic sel_fall;
    logic sel_rise;
    logic clk_rise;
    logic clk_fall;
  } pin_evt_t;

  // Serial clock events count only when select was low on both samples,
  // so they never coincide with a select edge.
  function automatic pin_evt_t find_events(input logic sel_now, input logic sel_prev,
                                           input logic sck_now, input logic sck_prev);
    pin_evt_t e;
    e.sel_fall = sel_prev & ~sel_now;
    e.sel_rise = ~sel_prev & sel_now;
    e.clk_rise = ~sel_now & ~sel_prev & ~sck_prev & sck_now;
    e.clk_fall = ~sel_now & ~sel_prev & sck_prev & ~sck_now;
    return e;
  endfunction

endpackage

// File: rtl/cfs_sync.sv
`timescale 1ns/1ps
module cfs_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
      else        chain <= {chain[STAGES-2:0], d_async[i]};
    end
    assign q_sync[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/cfs_edge.sv
`timescale 1ns/1ps
module cfs_edge
  import cfs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sel_s,
  input  logic     sck_s,
  output pin_evt_t evt
);
  logic sel_d, sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_d <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      sel_d <= sel_s;
      sck_d <= sck_s;
    end
  end

  assign evt = find_events(sel_s, sel_d, sck_s, sck_d);

  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({evt.sel_fall, evt.sel_rise, evt.clk_rise, evt.clk_fall}) <= 1); // R3
endmodule

// File: rtl/cfs_shifter.sv
`timescale 1ns/1ps
module cfs_shifter
  import cfs_pkg::*;
#(
  parameter int CH = 4,
  localparam int CNT_W = $clog2(CH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pin_evt_t      evt,
  input  logic          sdi_s,
  input  logic [CH-1:0] fault_in,
  output logic          sdo,
  output logic          sdo_oe,
  output logic [CH-1:0] last_bits,
  output logic          frame_full
);
  logic [CH-1:0]    shreg;
  logic [CNT_W-1:0] nbits;
  logic             sdo_q, oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      nbits <= '0;
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (evt.sel_fall) begin
      shreg <= fault_in;
      sdo_q <= fault_in[CH-1];
      oe_q  <= 1'b1;
      nbits <= '0;
    end else if (evt.sel_rise) begin
      oe_q <= 1'b0;
    end else if (evt.clk_rise) begin
      shreg <= {shreg[CH-2:0], sdi_s};
      if (nbits != CNT_W'(CH)) nbits <= nbits + 1'b1;
    end else if (evt.clk_fall) begin
      sdo_q <= shreg[CH-1];
    end
  end

  assign sdo        = sdo_q;
  assign sdo_oe     = oe_q;
  assign last_bits  = shreg;
  assign frame_full = (nbits == CNT_W'(CH));

  AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    evt.sel_fall |=> sdo_oe); // R2
  AST_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
    evt.sel_fall |=> (sdo == $past(fault_in[CH-1]))); // R2
  AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    evt.clk_rise |=> $stable(sdo)); // R3
  AST_OE_OFF_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    evt.sel_rise |=> !sdo_oe); // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    nbits <= CNT_W'(CH)); // R5
endmodule

// File: rtl/cmd_fault_shifter.sv
`timescale 1ns/1ps
module cmd_fault_shifter
  import cfs_pkg::*;
#(
  parameter int CH = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          ser_clk,
  input  logic          ser_in,
  input  logic [CH-1:0] fault_live,
  output logic          ser_out,
  output logic          ser_out_en,
  output logic [CH-1:0] ctrl_q,
  output logic          fault_rearm
);
  logic          sel_s, sck_s, sdi_s;
  pin_evt_t      evt;
  logic [CH-1:0] last_bits;
  logic          frame_full;
  logic          rearm_q;
  logic [CH-1:0] ctrl_r;

  cfs_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({sel_n, ser_clk, ser_in}),
    .q_sync({sel_s, sck_s, sdi_s})
  );

  cfs_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .sck_s(sck_s), .evt(evt)
  );

  cfs_shifter #(.CH(CH)) u_shift (
    .clk(clk), .rst_n(rst_n), .evt(evt), .sdi_s(sdi_s), .fault_in(fault_live),
    .sdo(ser_out), .sdo_oe(ser_out_en), .last_bits(last_bits), .frame_full(frame_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_r  <= '0;
      rearm_q <= 1'b0;
    end else begin
      rearm_q <= evt.sel_rise;
      if (evt.sel_rise && frame_full) ctrl_r <= last_bits;
    end
  end

  assign ctrl_q      = ctrl_r;
  assign fault_rearm = rearm_q;

  AST_CTRL_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !evt.sel_rise |=> $stable(ctrl_q)); // R4
  AST_SHORT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.sel_rise && !frame_full) |=> $stable(ctrl_q)); // R5
  AST_REARM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_rearm |=> !fault_rearm); // R8
  AST_REARM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    evt.sel_rise |=> fault_rearm); // R8
endmodule

// File: tb/sim_cmd_fault_shifter.sv
`timescale 1ns/1ps
module sim_cmd_fault_shifter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_n = 1'b1, ser_clk = 1'b0, ser_in = 1'b0;
  logic [3:0] fault_live = 4'h0;
  logic       ser_out, ser_out_en, fault_rearm;
  logic [3:0] ctrl_q;
  int         n_tests = 0, n_fail = 0, rearm_cnt = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  cmd_fault_shifter u0 (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ser_clk(ser_clk), .ser_in(ser_in),
    .fault_live(fault_live), .ser_out(ser_out), .ser_out_en(ser_out_en),
    .ctrl_q(ctrl_q), .fault_rearm(fault_rearm)
  );

  always @(posedge clk) if (rst_n && fault_rearm) rearm_cnt <= rearm_cnt + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends n bits (bits[n-1] first) with fault snapshot flt; fault_live moves to flt_mid mid-frame.
  task automatic run_frame(input logic [15:0] bits, input int n, input logic [3:0] flt,
                           input logic [3:0] flt_mid, input string tag);
    int rc0;
    logic exp;
    fault_live = flt;
    wait_clk(4);
    rc0 = rearm_cnt;
    sel_n = 1'b0;
    wait_clk(6);
    fault_live = flt_mid;
    chk(ser_out_en == 1'b1, {tag, " R2 oe"}, ser_out_en, 1);
    chk(ser_out == flt[3], {tag, " R2 first bit"}, ser_out, flt[3]);
    for (int i = 0; i < n; i++) begin
      ser_in = bits[n-1-i];
      wait_clk(4);
      ser_clk = 1'b1;
      exp = ser_out;
      wait_clk(4);
      chk(ser_out == exp, {tag, " R3 hold across rise"}, ser_out, exp);
      ser_clk = 1'b0;
      wait_clk(4);
      if (i + 1 < 4) exp = flt[2-i];
      else           exp = bits[n-1-(i+1-4)];
      if (i + 1 < n + 4)
        chk(ser_out == exp, {tag, " R3/R7 stream"}, ser_out, exp);
    end
    wait_clk(4);
    sel_n = 1'b1;
    wait_clk(6);
    chk(ser_out_en == 1'b0, {tag, " R8 oe off"}, ser_out_en, 0);
    chk(rearm_cnt == rc0 + 1, {tag, " R8 rearm count"}, rearm_cnt, rc0 + 1);
  endtask

  task automatic t_reset;
    chk(ctrl_q == 4'h0, "R1 ctrl in reset", ctrl_q, 0);
    chk(ser_out_en == 1'b0, "R1 oe in reset", ser_out_en, 0);
    rst_n = 1'b1;
    wait_clk(4);
    chk(ctrl_q == 4'h0 && ser_out_en == 1'b0 && fault_rearm == 1'b0, "R1 after release",
        {ctrl_q, ser_out_en, fault_rearm}, 0);
  endtask

  task automatic t_basic;
    run_frame(16'h000B, 4, 4'b1010, 4'b1010, "basic");
    chk(ctrl_q == 4'hB, "R4 commit 1011", ctrl_q, 4'hB);
    run_frame(16'h0006, 4, 4'b0101, 4'b0101, "basic2");
    chk(ctrl_q == 4'h6, "R4 commit 0110", ctrl_q, 4'h6);
  endtask

  task automatic t_short;
    run_frame(16'h0001, 3, 4'b1100, 4'b1100, "short3");
    chk(ctrl_q == 4'h6, "R5 three-bit frame", ctrl_q, 4'h6);
    run_frame(16'h0000, 0, 4'b0011, 4'b0011, "empty");
    chk(ctrl_q == 4'h6, "R5 empty frame", ctrl_q, 4'h6);
  endtask

  task automatic t_long;
    run_frame(16'h00C5, 8, 4'b1001, 4'b1001, "long8");
    chk(ctrl_q == 4'h5, "R6 last four of eight", ctrl_q, 4'h5);
    run_frame(16'h0013, 5, 4'b0000, 4'b0000, "long5");
    chk(ctrl_q == 4'h3, "R6 last four of five", ctrl_q, 4'h3);
  endtask

  task automatic t_fault_mid;
    run_frame(16'h000F, 4, 4'b0110, 4'b1001, "faultmid");
    chk(ctrl_q == 4'hF, "R7 frame still commits", ctrl_q, 4'hF);
  endtask

  task automatic t_idle_clock;
    int rc0;
    rc0 = rearm_cnt;
    for (int i = 0; i < 6; i++) begin
      ser_in = i[0];
      ser_clk = 1'b1; wait_clk(4);
      ser_clk = 1'b0; wait_clk(4);
    end
    chk(ctrl_q == 4'hF, "R9 ctrl unchanged while idle", ctrl_q, 4'hF);
    chk(ser_out_en == 1'b0, "R9 oe stays off while idle", ser_out_en, 0);
    chk(rearm_cnt == rc0, "R9 no rearm while idle", rearm_cnt, rc0);
    run_frame(16'h0008, 4, 4'b1110, 4'b1110, "R9 after idle");
    chk(ctrl_q == 4'h8, "R9 next frame commits", ctrl_q, 4'h8);
  endtask

  initial begin
    wait_clk(5);
    t_reset();
    t_basic();
    t_short();
    t_long();
    t_fault_mid();
    t_idle_clock();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule